// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block is the shared register bank for a group of DMA channels (sixteen by default). Software programs it over a simple word bus with a single-cycle write strobe. Each channel's own engine reports each finished descriptor with a completion event. It reports a fault with an error event, which comes with a flag telling a bus fault apart from a termination fault. The bank keeps these events as sticky flags and holds the per-channel interrupt enables. From them it drives per-channel freeze levels, one-cycle channel reset pulses, per-channel interrupt lines and one global interrupt.

Each register has three write addresses. The base address replaces the value. Base+4 ORs the written ones in. Base+8 clears the written ones. Software can therefore acknowledge or enable one channel without a read-modify-write race against the other channels. A termination fault that arrives together with a completion for the same channel counts as a clean end, not as an error. Only bus faults, and termination faults with no matching completion, reach the effective-error outputs.

Top module: `dmac_csr_bank`

## Requirements
- R1: After reset every stored bit is 0. `ch_freeze`, `ch_reset`, `ch_irq`, `eff_err` and `irq` are all 0.
- R2: The address map is as follows. 0x000 holds the burst-enable word. 0x010 holds completion flags in bits [15:0] and interrupt enables in bits [31:16]. 0x020 holds error flags in bits [15:0] and fault-kind markers in bits [31:16]. 0x030 holds freeze bits in [15:0] and reset triggers in [31:16]. 0x800 holds the version word. Address bits [3:2] select the write alias: 00 replaces, 01 ORs, 10 clears the ones written, and 11 is ignored. A write with bits [1:0] not 00 is ignored. `bus_rdata` shows the register at `bus_addr` in the same cycle and ignores the alias bits.
- R3: A high `cmpl_evt[n]` sets completion flag n (0x010 bit n) at the next clock edge. The flag stays set until software clears it.
- R4: A high `err_evt[n]` sets error flag n (0x020 bit n) at the next clock edge. The same edge sets marker bit 16+n to 1 if `err_is_bus[n]` is high (bus fault) and to 0 otherwise (termination fault).
- R5: `ch_freeze[n]` follows bit n of 0x030 from the cycle after the write. All three aliases act on it.
- R6: A write of 1 to 0x030 bit 16+n through the replace or OR alias makes `ch_reset[n]` high for exactly the next cycle. The clear alias gives no pulse. Bits [31:16] of 0x030 read as 0.
- R7: `eff_err[n]` is high when error flag n is set and either marker n is 1, or marker n is 0 and completion flag n is 0.
- R8: `ch_irq[n]` equals (completion flag n AND enable n) OR `eff_err[n]`. `irq` is the OR of all bits of `ch_irq`.
- R9: When a channel event and a software write act on the same flag bit in the same cycle, the event wins and the bit ends up set.
- R10: 0x800 reads as VERSION_MAJOR in bits [31:24] and 0 elsewhere, and writes to it are ignored. At 0x000 only bits 29 and 28 are stored, and the other bits read 0. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cmpl_evt | input | NCH | Per-channel completion event |
| err_evt | input | NCH | Per-channel error event |
| err_is_bus | input | NCH | Fault kind with `err_evt`: 1 bus, 0 termination |
| ch_freeze | output | NCH | Per-channel freeze level |
| ch_reset | output | NCH | Per-channel one-cycle reset pulse |
| ch_irq | output | NCH | Per-channel interrupt |
| eff_err | output | NCH | Per-channel effective error |
| irq | output | 1 | Global interrupt |

## Verification
Some rules hold on every cycle and are checked there. Effective errors only ever come from stored error flags. A termination fault with a matching completion never shows as an effective error. Every interrupt traces back to a stored flag. Freeze levels move only after a bus write, a reset pulse only follows a write to the channel-control word, and an event's flag is always set on the next edge. Other behaviour needs the bench's scenarios: the value each alias produces, the bits that read 0 on each register, the ignored addresses, the fault-kind marker, and the case where an event and a software clear hit the same cycle.

// File: rtl/dmac_csr_pkg.sv
package dmac_csr_pkg;

  localparam int MAX_CH = 16;
  localparam int DW     = 32;

  typedef enum logic [1:0] {
    ALIAS_WR   = 2'd0,
    ALIAS_SET  = 2'd1,
    ALIAS_CLR  = 2'd2,
    ALIAS_NONE = 2'd3
  } alias_e;

  typedef enum logic [2:0] {
    SEL_BURST,
    SEL_STAT,
    SEL_ERR,
    SEL_CHCTL,
    SEL_VER,
    SEL_NONE
  } sel_e;

  localparam logic [7:0] PAGE_BURST = 8'h00;
  localparam logic [7:0] PAGE_STAT  = 8'h01;
  localparam logic [7:0] PAGE_ERR   = 8'h02;
  localparam logic [7:0] PAGE_CHCTL = 8'h03;
  localparam logic [7:0] PAGE_VER   = 8'h80;

  localparam logic [DW-1:0] BURST_MASK = 32'h3000_0000;

  // Result of one software write through the selected alias.
  function automatic logic [DW-1:0] apply_alias(input logic [DW-1:0] cur,
                                                input logic [DW-1:0] wd,
                                                input alias_e kind);
    case (kind)
      ALIAS_WR:  return wd;
      ALIAS_SET: return cur | wd;
      ALIAS_CLR: return cur & ~wd;
      default:   return cur;
    endcase
  endfunction

  // Both halves of a status word carry one bit per implemented channel.
  function automatic logic [DW-1:0] chan_mask(input int nch);
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < MAX_CH; i++) begin
      if (i < nch) begin
        m[i]          = 1'b1;
        m[MAX_CH + i] = 1'b1;
      end
    end
    return m;
  endfunction

  // Bus fault always counts; a termination fault counts only without completion.
  function automatic logic [MAX_CH-1:0] eff_err_calc(input logic [MAX_CH-1:0] err,
                                                     input logic [MAX_CH-1:0] bus,
                                                     input logic [MAX_CH-1:0] cmpl);
    return (err & bus) | (err & ~bus & ~cmpl);
  endfunction

endpackage

// File: rtl/dmac_csr_decode.sv
module dmac_csr_decode
  import dmac_csr_pkg::*;
(
  input  logic [11:0] addr,
  output sel_e        sel,
  output alias_e      kind
);

  logic [7:0] page;
  assign page = addr[11:4];

  always_comb begin
    case (page)
      PAGE_BURST: sel = SEL_BURST;
      PAGE_STAT:  sel = SEL_STAT;
      PAGE_ERR:   sel = SEL_ERR;
      PAGE_CHCTL: sel = SEL_CHCTL;
      PAGE_VER:   sel = SEL_VER;
      default:    sel = SEL_NONE;
    endcase
  end

  // Unaligned offsets and the fourth alias slot make a write do nothing.
  always_comb begin
    if (addr[1:0] != 2'b00) kind = ALIAS_NONE;
    else                    kind = alias_e'(addr[3:2]);
  end

endmodule

// File: rtl/dmac_alias_reg.sv
module dmac_alias_reg
  import dmac_csr_pkg::*;
#(
  parameter int            W     = 32,
  parameter logic [W-1:0]  WMASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hit,
  input  alias_e       kind,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hw_set,
  input  logic [W-1:0] hw_clr,
  output logic [W-1:0] q
);

  logic [DW-1:0] sw_wide;
  logic [W-1:0]  sw_next;
  logic [W-1:0]  nxt;

  assign sw_wide = apply_alias(DW'(q), DW'(wdata), kind);
  assign sw_next = wr_hit ? sw_wide[W-1:0] : q;
  // Channel events are applied after software so that they are never lost.
  assign nxt     = ((sw_next & ~hw_clr) | hw_set) & WMASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

endmodule

// File: rtl/dmac_irq_combine.sv
module dmac_irq_combine
  import dmac_csr_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic [NCH-1:0] cmpl,
  input  logic [NCH-1:0] en,
  input  logic [NCH-1:0] err,
  input  logic [NCH-1:0] bus,
  output logic [NCH-1:0] eff_err,
  output logic [NCH-1:0] ch_irq,
  output logic           irq
);

  logic [MAX_CH-1:0] eff_w;

  assign eff_w   = eff_err_calc(MAX_CH'(err), MAX_CH'(bus), MAX_CH'(cmpl));
  assign eff_err = eff_w[NCH-1:0];

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      assign ch_irq[g] = (cmpl[g] & en[g]) | eff_err[g];
    end
  endgenerate

  assign irq = |ch_irq;

endmodule

// File: rtl/dmac_csr_bank.sv
module dmac_csr_bank
  import dmac_csr_pkg::*;
#(
  parameter int         NCH           = 16,
  parameter logic [7:0] VERSION_MAJOR = 8'd3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [11:0]    bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  input  logic [NCH-1:0] cmpl_evt,
  input  logic [NCH-1:0] err_evt,
  input  logic [NCH-1:0] err_is_bus,
  output logic [NCH-1:0] ch_freeze,
  output logic [NCH-1:0] ch_reset,
  output logic [NCH-1:0] ch_irq,
  output logic [NCH-1:0] eff_err,
  output logic           irq
);

  localparam logic [DW-1:0] STAT_MASK = chan_mask(NCH);

  sel_e   sel;
  alias_e kind;

  dmac_csr_decode u_dec (
    .addr (bus_addr),
    .sel  (sel),
    .kind (kind)
  );

  logic hit_burst, hit_stat, hit_err, hit_chctl;
  assign hit_burst = bus_wr && (sel == SEL_BURST) && (kind != ALIAS_NONE);
  assign hit_stat  = bus_wr && (sel == SEL_STAT)  && (kind != ALIAS_NONE);
  assign hit_err   = bus_wr && (sel == SEL_ERR)   && (kind != ALIAS_NONE);
  assign hit_chctl = bus_wr && (sel == SEL_CHCTL) && (kind != ALIAS_NONE);

  // Channel events widened to the register layout.
  logic [MAX_CH-1:0] cmpl_w, err_w, busf_w, termf_w;
  assign cmpl_w  = MAX_CH'(cmpl_evt);
  assign err_w   = MAX_CH'(err_evt);
  assign busf_w  = MAX_CH'(err_evt & err_is_bus);
  assign termf_w = MAX_CH'(err_evt & ~err_is_bus);

  logic [DW-1:0] stat_set, err_set, err_clr;
  assign stat_set = {{MAX_CH{1'b0}}, cmpl_w};
  assign err_set  = {busf_w, err_w};
  assign err_clr  = {termf_w, {MAX_CH{1'b0}}};

  logic [DW-1:0] burst_q, stat_q, err_q;

  dmac_alias_reg #(.W(DW), .WMASK(BURST_MASK)) u_burst (
    .clk(clk), .rst_n(rst_n), .wr_hit(hit_burst), .kind(kind),
    .wdata(bus_wdata), .hw_set('0), .hw_clr('0), .q(burst_q)
  );

  dmac_alias_reg #(.W(DW), .WMASK(STAT_MASK)) u_stat (
    .clk(clk), .rst_n(rst_n), .wr_hit(hit_stat), .kind(kind),
    .wdata(bus_wdata), .hw_set(stat_set), .hw_clr('0), .q(stat_q)
  );

  dmac_alias_reg #(.W(DW), .WMASK(STAT_MASK)) u_err (
    .clk(clk), .rst_n(rst_n), .wr_hit(hit_err), .kind(kind),
    .wdata(bus_wdata), .hw_set(err_set), .hw_clr(err_clr), .q(err_q)
  );

  logic [NCH-1:0] freeze_q;

  dmac_alias_reg #(.W(NCH), .WMASK({NCH{1'b1}})) u_freeze (
    .clk(clk), .rst_n(rst_n), .wr_hit(hit_chctl), .kind(kind),
    .wdata(bus_wdata[NCH-1:0]), .hw_set('0), .hw_clr('0), .q(freeze_q)
  );

  // Reset triggers are not stored: they become a one-cycle pulse.
  logic           rst_trig;
  logic [NCH-1:0] rst_pulse_q;
  assign rst_trig = hit_chctl && ((kind == ALIAS_WR) || (kind == ALIAS_SET));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rst_pulse_q <= '0;
    else if (rst_trig) rst_pulse_q <= bus_wdata[MAX_CH +: NCH];
    else               rst_pulse_q <= '0;
  end

  // Named views of the stored state, used by the combiner and the checker.
  logic [NCH-1:0] stat_cmpl, stat_en, err_flag, err_mark;
  assign stat_cmpl = stat_q[NCH-1:0];
  assign stat_en   = stat_q[MAX_CH +: NCH];
  assign err_flag  = err_q[NCH-1:0];
  assign err_mark  = err_q[MAX_CH +: NCH];

  dmac_irq_combine #(.NCH(NCH)) u_irq (
    .cmpl    (stat_cmpl),
    .en      (stat_en),
    .err     (err_flag),
    .bus     (err_mark),
    .eff_err (eff_err),
    .ch_irq  (ch_irq),
    .irq     (irq)
  );

  assign ch_freeze = freeze_q;
  assign ch_reset  = rst_pulse_q;

  always_comb begin
    case (sel)
      SEL_BURST: bus_rdata = burst_q;
      SEL_STAT:  bus_rdata = stat_q;
      SEL_ERR:   bus_rdata = err_q;
      SEL_CHCTL: bus_rdata = DW'(freeze_q);
      SEL_VER:   bus_rdata = {VERSION_MAJOR, 24'h0};
      default:   bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/dmac_csr_bank_chk.sv
module dmac_csr_bank_chk #(
  parameter int NCH = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_wr,
  input logic [11:0]    bus_addr,
  input logic [NCH-1:0] cmpl_evt,
  input logic [NCH-1:0] ch_freeze,
  input logic [NCH-1:0] ch_reset,
  input logic [NCH-1:0] ch_irq,
  input logic [NCH-1:0] eff_err,
  input logic [NCH-1:0] cmpl_q,
  input logic [NCH-1:0] en_q,
  input logic [NCH-1:0] err_q,
  input logic [NCH-1:0] mark_q
);

  a_r3_event_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmpl_evt) |=> ((cmpl_q & $past(cmpl_evt)) == $past(cmpl_evt)));

  a_r5_freeze_moves_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(ch_freeze));

  a_r6_pulse_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_reset) |-> $past(bus_wr && (bus_addr[11:4] == 8'h03) && (bus_addr[3:2] != 2'b10)));

  a_r7_err_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_err & ~err_q) == '0);

  a_r7_term_with_cmpl_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_err & ~mark_q & cmpl_q) == '0);

  a_r8_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_irq & ~((cmpl_q & en_q) | err_q)) == '0);

endmodule

bind dmac_csr_bank dmac_csr_bank_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .cmpl_evt  (cmpl_evt),
  .ch_freeze (ch_freeze),
  .ch_reset  (ch_reset),
  .ch_irq    (ch_irq),
  .eff_err   (eff_err),
  .cmpl_q    (stat_cmpl),
  .en_q      (stat_en),
  .err_q     (err_flag),
  .mark_q    (err_mark)
);

// File: tb/dmac_csr_bank_tb.sv
`timescale 1ns/1ps
module dmac_csr_bank_tb_top;

  localparam int NCH = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bus_wr = 1'b0;
  logic [11:0]    bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic [NCH-1:0] cmpl_evt = '0;
  logic [NCH-1:0] err_evt = '0;
  logic [NCH-1:0] err_is_bus = '0;
  logic [NCH-1:0] ch_freeze, ch_reset, ch_irq, eff_err;
  logic           irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  dmac_csr_bank #(.NCH(NCH), .VERSION_MAJOR(8'd3)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmpl_evt(cmpl_evt),
    .err_evt(err_evt), .err_is_bus(err_is_bus), .ch_freeze(ch_freeze),
    .ch_reset(ch_reset), .ch_irq(ch_irq), .eff_err(eff_err), .irq(irq)
  );

  // {write address, write data, expected read at the page base}
  localparam logic [75:0] VEC [16] = '{
    {12'h010, 32'h0000_0000, 32'h0000_0000},  // R2 replace
    {12'h014, 32'h00F0_0000, 32'h00F0_0000},  // R2 OR alias
    {12'h014, 32'h0000_0011, 32'h00F0_0011},
    {12'h018, 32'h0030_0001, 32'h00C0_0010},  // R2 clear alias
    {12'h010, 32'h1234_5678, 32'h1234_5678},
    {12'h01C, 32'hFFFF_FFFF, 32'h1234_5678},  // R2 fourth slot ignored
    {12'h018, 32'hFFFF_FFFF, 32'h0000_0000},
    {12'h000, 32'hFFFF_FFFF, 32'h3000_0000},  // R10 burst bits only
    {12'h008, 32'h1000_0000, 32'h2000_0000},
    {12'h800, 32'hFFFF_FFFF, 32'h0300_0000},  // R10 version
    {12'h034, 32'h0000_00A5, 32'h0000_00A5},  // R5 freeze set
    {12'h038, 32'h0000_0005, 32'h0000_00A0},
    {12'h020, 32'hABCD_0000, 32'hABCD_0000},
    {12'h011, 32'hFFFF_FFFF, 32'h0000_0000},  // R2 unaligned ignored (reads 0x010)
    {12'h030, 32'hFFFF_0000, 32'h0000_0000},  // R6 trigger bits read 0
    {12'h400, 32'hFFFF_FFFF, 32'h0000_0000}   // R10 unmapped
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic evt(input logic [NCH-1:0] c, input logic [NCH-1:0] e, input logic [NCH-1:0] b);
    @(negedge clk);
    cmpl_evt = c; err_evt = e; err_is_bus = b;
    @(negedge clk);
    cmpl_evt = '0; err_evt = '0; err_is_bus = '0;
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(12'h000, r); check("R1 burst", r, 32'h0);
    rd(12'h010, r); check("R1 status", r, 32'h0);
    rd(12'h020, r); check("R1 error", r, 32'h0);
    rd(12'h030, r); check("R1 chctl", r, 32'h0);
    check("R1 outputs", {ch_freeze, ch_reset}, 32'h0);
    check("R1 irq", {ch_irq, eff_err}, 32'h0);
    check("R1 global irq", 32'(irq), 32'h0);

    foreach (VEC[i]) begin
      wr(VEC[i][75:64], VEC[i][63:32]);
      rd({VEC[i][75:68], 4'h0}, r);
      check($sformatf("R2 vector %0d", i), r, VEC[i][31:0]);
    end
    wr(12'h020, 32'h0);
    wr(12'h010, 32'h0);
    @(negedge clk);

    // R3 completion event, R8 gating by enable
    evt(16'h0020, '0, '0);
    rd(12'h010, r); check("R3 flag set", r, 32'h0000_0020);
    check("R8 no irq without enable", {31'h0, irq}, 32'h0);
    @(negedge clk); @(negedge clk);
    rd(12'h010, r); check("R3 flag sticky", r, 32'h0000_0020);
    wr(12'h014, 32'h0020_0000);
    check("R8 ch_irq enabled", 32'(ch_irq), 32'h0020);
    check("R8 global irq", 32'(irq), 32'h1);
    wr(12'h018, 32'h0000_0020);
    check("R8 irq after ack", 32'(irq), 32'h0);

    // R4 / R7 fault kinds
    evt('0, 16'h0004, 16'h0000);
    rd(12'h020, r); check("R4 termination fault", r, 32'h0000_0004);
    check("R7 term alone is error", 32'(eff_err), 32'h0004);
    check("R8 error raises ch_irq", 32'(ch_irq), 32'h0004);
    evt(16'h0004, '0, '0);
    check("R7 term with completion masked", 32'(eff_err), 32'h0000);
    evt(16'h0200, 16'h0200, 16'h0200);
    rd(12'h020, r); check("R4 bus fault marker", r, 32'h0200_0204);
    check("R7 bus fault despite completion", 32'(eff_err), 32'h0200);
    check("R8 ch_irq from bus fault", 32'(ch_irq), 32'h0200);
    evt('0, 16'h0200, 16'h0000);
    rd(12'h020, r); check("R4 marker cleared by termination", r, 32'h0000_0204);
    check("R7 term after completion", 32'(eff_err), 32'h0000);

    // R9 event beats a simultaneous clear
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 12'h018; bus_wdata = 32'h0000_FFFF; cmpl_evt = 16'h0008;
    @(negedge clk);
    bus_wr = 1'b0; cmpl_evt = '0;
    rd(12'h010, r); check("R9 event wins", r & 32'h0000_FFFF, 32'h0000_0008);

    // R5 freeze, R6 reset pulses
    wr(12'h030, 32'h0004_0003);
    check("R5 freeze level", 32'(ch_freeze), 32'h0003);
    check("R6 pulse from replace", 32'(ch_reset), 32'h0004);
    @(negedge clk);
    check("R6 pulse one cycle", 32'(ch_reset), 32'h0000);
    wr(12'h038, 32'h0008_0000);
    check("R6 clear alias no pulse", 32'(ch_reset), 32'h0000);
    check("R5 freeze kept", 32'(ch_freeze), 32'h0003);
    wr(12'h034, 32'h0001_0000);
    check("R6 pulse from OR alias", 32'(ch_reset), 32'h0001);
    wr(12'h038, 32'h0000_0001);
    check("R5 freeze clear alias", 32'(ch_freeze), 32'h0002);

    report();
  end

endmodule